// File: doc/BRIEF.md
# Remote PROM configuration sequencer

This engine sits inside a board control FPGA. It moves configuration images from a shared SRAM into a serial configuration PROM over a JTAG link. A host first fills the SRAM and then issues a store command. The engine then takes the SRAM away from the host and erases the PROM. Next it programs one data-register scan per image word and reads every word back through JTAG. The read-back copy lands in SRAM, just above the image, where the host can compare it. When that is finished the engine gives the SRAM back and raises done.

An image can arrive as several segments. Each segment is a separate store, and the command for a segment says whether it is the final one. The host sends a reconfigure command after the final segment has been stored and checked. That command makes the engine send the PROM its "load target FPGA" instruction. A chain field picks which of several PROM/FPGA JTAG chains the run drives. The JTAG clock comes from the system clock through a divider that can be set at run time.

Top module: `prom_cfg_seq`

## Requirements
- R1: After reset and with no command the block is idle. busy, done and err are 0, host_gnt is 1, chain_en is 0, jtag_tck is 0, and no JTAG instruction is issued.
- R2: A store command with cmd_reconf=0 is accepted only when the block is idle. From acceptance until read-back ends, busy=1 and host_gnt=0. During that time host writes do not reach the SRAM and host_rdata reads 0.
- R3: A store issues instruction ERASE (8'h0D) and then PROGRAM (8'h06). It then performs exactly cmd_len data scans, one for each 16-bit word read from SRAM addresses cmd_base to cmd_base+cmd_len-1, each shifted LSB first.
- R4: After programming, the block issues READ (8'h05) and performs cmd_len data scans. It writes word i, taken from TDO, to SRAM address cmd_base+cmd_len+i.
- R5: At the end of read-back the block drops busy, raises done and returns host_gnt to 1.
- R6: A reconfigure command (cmd_reconf=1) issues instruction CONFIG (8'h0E) and then sets done. It is allowed only if the most recent store had cmd_last=1 and no reconfigure has run since that store. Otherwise err is set and nothing is shifted.
- R7: A store with cmd_last=0 leaves the block unable to reconfigure until a later store with cmd_last=1 completes.
- R8: During a run only chain_en[cmd_chain] is high, and TDO is taken from that chain. A store with cmd_chain >= NCH is rejected with err=1.
- R9: A command that arrives while busy sets err and is dropped. The run in progress finishes unchanged. The next accepted command clears err.
- R10: Each TCK half period lasts clk_div+1 system clocks. TMS and TDI change only as TCK falls, and TDO is sampled as TCK rises.
- R11: A store with cmd_len=0 is rejected with err=1 and no JTAG activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_div | input | DIVW | TCK half period minus one, in system clocks |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_reconf | input | 1 | 1 = reconfigure, 0 = store |
| cmd_chain | input | CHW | Target chain index |
| cmd_base | input | AW | SRAM address of the segment's first word |
| cmd_len | input | LW | Segment length in words |
| cmd_last | input | 1 | Segment is the final one of the image |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run finished |
| err | output | 1 | The last command was rejected |
| host_gnt | output | 1 | Host owns the SRAM |
| host_addr | input | AW | Host SRAM address |
| host_we | input | 1 | Host SRAM write enable |
| host_wdata | input | 16 | Host SRAM write data |
| host_rdata | output | 16 | Host SRAM read data (0 while not granted) |
| sram_addr | output | AW | SRAM address |
| sram_we | output | 1 | SRAM write enable |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data, one cycle after the address |
| jtag_tck | output | 1 | JTAG clock |
| jtag_tms | output | 1 | JTAG mode select |
| jtag_tdi | output | 1 | JTAG data to the PROM |
| jtag_tdo | input | NCH | JTAG data from each chain |
| chain_en | output | NCH | One-hot active chain |

## Verification
The bench runs a behavioural TAP and PROM model and checks the order of instruction codes and every programmed word. A wrong fetch address or a bad bit order shows up as a corrupted PROM word. Reading TDO on the wrong TCK edge shifts the read-back copy by one bit. The bench also checks that read-back lands above the image and not over it. It then goes after the gating corners: reconfigure before the final segment, a second reconfigure, a store issued while busy, an out-of-range chain and a zero length. Each of these must set err without disturbing the PROM. A design that rejected too little would reprogram or reload the target, and one that rejected too much would hang the host. The measured TCK half period with a changed divider catches an off-by-one in the divider.

// File: rtl/prom_cfg_pkg.sv
// Shared constants, op-code table and JTAG scan-frame builders.
// Assumes the TAP rests in Run-Test/Idle between scans.
package prom_cfg_pkg;
    localparam int DW   = 16;
    localparam int IR_W = 8;
    localparam int FR   = (IR_W + 6 > DW + 5) ? IR_W + 6 : DW + 5;
    localparam int LENW = $clog2(FR + 1);

    typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_READ, OP_CONFIG} op_e;

    typedef struct packed {
        logic [LENW-1:0] len;
        logic [FR-1:0]   tms;
        logic [FR-1:0]   tdi;
    } frame_t;

    // Instruction value for each PROM operation.
    function automatic logic [IR_W-1:0] op_code(op_e o);
        case (o)
            OP_ERASE: return IR_W'(8'h0D);
            OP_PROG:  return IR_W'(8'h06);
            OP_READ:  return IR_W'(8'h05);
            default:  return IR_W'(8'h0E);
        endcase
    endfunction

    // Idle -> Shift-IR, shift code, Exit1 -> Update -> Idle.
    function automatic frame_t ir_frame(op_e o);
        frame_t f = '0;
        logic [IR_W-1:0] c = op_code(o);
        f.len    = LENW'(IR_W + 6);
        f.tms[0] = 1'b1;
        f.tms[1] = 1'b1;
        for (int i = 0; i < IR_W; i++) f.tdi[4+i] = c[i];
        f.tms[4+IR_W-1] = 1'b1;
        f.tms[4+IR_W]   = 1'b1;
        return f;
    endfunction

    // Idle -> Shift-DR, shift word LSB first, Exit1 -> Update -> Idle.
    function automatic frame_t dr_frame(logic [DW-1:0] w);
        frame_t f = '0;
        f.len    = LENW'(DW + 5);
        f.tms[0] = 1'b1;
        for (int i = 0; i < DW; i++) f.tdi[3+i] = w[i];
        f.tms[3+DW-1] = 1'b1;
        f.tms[3+DW]   = 1'b1;
        return f;
    endfunction
endpackage

// File: rtl/prom_jtag_scan.sv
// Bit-level JTAG master: plays one frame of TMS/TDI bits at a divided TCK
// and collects TDO per bit. TMS/TDI move with TCK falling, TDO is taken
// as TCK rises. Assumes start is only pulsed while busy is low.
module prom_jtag_scan
    import prom_cfg_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] clk_div,
    input  logic            start,
    input  frame_t          frame,
    output logic            busy,
    output logic            done,
    output logic [FR-1:0]   tdo_vec,
    output logic            tck,
    output logic            tms,
    output logic            tdi,
    input  logic            tdo_i
);
    typedef enum logic [1:0] {E_IDLE, E_LOW, E_HIGH} est_e;
    est_e            st;
    logic [DIVW-1:0] cnt;
    logic [LENW-1:0] bitn, len;
    logic [FR-1:0]   tms_sr, tdi_sr;

    assign busy = (st != E_IDLE);

    // Half-period timing, bit shifting and TDO capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= E_IDLE; cnt <= '0; bitn <= '0; len <= '0;
            tms_sr <= '0; tdi_sr <= '0; tdo_vec <= '0;
            tck <= 1'b0; tms <= 1'b0; tdi <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                E_IDLE: if (start) begin
                    len    <= frame.len;
                    tms    <= frame.tms[0];
                    tdi    <= frame.tdi[0];
                    tms_sr <= frame.tms >> 1;
                    tdi_sr <= frame.tdi >> 1;
                    bitn   <= '0;
                    cnt    <= clk_div;
                    st     <= E_LOW;
                end
                E_LOW: if (cnt == '0) begin
                    tck           <= 1'b1;
                    tdo_vec[bitn] <= tdo_i;
                    cnt           <= clk_div;
                    st            <= E_HIGH;
                end else cnt <= cnt - 1'b1;
                E_HIGH: if (cnt == '0) begin
                    tck <= 1'b0;
                    if (bitn == len - 1'b1) begin
                        done <= 1'b1; tms <= 1'b0; tdi <= 1'b0; st <= E_IDLE;
                    end else begin
                        bitn   <= bitn + 1'b1;
                        tms    <= tms_sr[0];
                        tdi    <= tdi_sr[0];
                        tms_sr <= tms_sr >> 1;
                        tdi_sr <= tdi_sr >> 1;
                        cnt    <= clk_div;
                        st     <= E_LOW;
                    end
                end else cnt <= cnt - 1'b1;
                default: st <= E_IDLE;
            endcase
        end
    end

    // R10: TMS/TDI never move in the cycle TCK rises.
    a_r10_pins_settled_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> ($stable(tms) && $stable(tdi)));
    // R3: a new frame is never launched over a running one.
    a_r3_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/prom_sram_arb.sv
// SRAM ownership mux: the host drives the SRAM unless the sequencer owns
// it, in which case host writes are dropped and host reads return zero.
module prom_sram_arb #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          own,
    input  logic [AW-1:0] host_addr,
    input  logic          host_we,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] seq_addr,
    input  logic          seq_we,
    input  logic [DW-1:0] seq_wdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_we,
    output logic [DW-1:0] sram_wdata,
    input  logic [DW-1:0] sram_rdata
);
    // Route the owner's request to the SRAM and gate the host's view.
    always_comb begin
        sram_addr  = own ? seq_addr  : host_addr;
        sram_we    = own ? seq_we    : host_we;
        sram_wdata = own ? seq_wdata : host_wdata;
        host_rdata = own ? '0        : sram_rdata;
    end
endmodule

// File: rtl/prom_cfg_ctrl.sv
// Command sequencer: accepts store / reconfigure commands, walks
// erase, program, read-back and release, and gates reconfigure on the
// final segment. Assumes SRAM read data is valid one cycle after the address.
module prom_cfg_ctrl
    import prom_cfg_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CHW = 2,
    parameter int AW  = 8,
    parameter int LW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic           cmd_reconf,
    input  logic [CHW-1:0] cmd_chain,
    input  logic [AW-1:0]  cmd_base,
    input  logic [LW-1:0]  cmd_len,
    input  logic           cmd_last,
    output logic           busy,
    output logic           done,
    output logic           err,
    output logic           own,
    output logic [NCH-1:0] chain_en,
    output logic [AW-1:0]  seq_addr,
    output logic           seq_we,
    output logic [DW-1:0]  seq_wdata,
    input  logic [DW-1:0]  seq_rdata,
    output logic           scan_start,
    output frame_t         scan_frame,
    input  logic           scan_done,
    input  logic [FR-1:0]  scan_tdo
);
    typedef enum logic [3:0] {
        S_IDLE, S_ERASE, S_PIR, S_FETCH, S_FWAIT, S_PDR,
        S_RIR, S_RDR, S_WBK, S_CFG
    } st_e;
    st_e            st;
    logic [AW-1:0]  base;
    logic [LW-1:0]  len, idx;
    logic [CHW-1:0] chain;
    logic           last_q, armed;
    logic [DW-1:0]  word;
    logic           at_end;

    assign at_end = (idx == len - LW'(1));

    // One enable per chain, high only for the active target.
    for (genvar k = 0; k < NCH; k++) begin : g_chain
        assign chain_en[k] = busy && (int'(chain) == k);
    end

    // SRAM request: fetch image words, then write the read-back copy above them.
    always_comb begin
        seq_we    = (st == S_WBK);
        seq_wdata = word;
        seq_addr  = (st == S_WBK) ? base + AW'(len) + AW'(idx) : base + AW'(idx);
    end

    // Main sequencing, command acceptance and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; base <= '0; len <= '0; idx <= '0; chain <= '0;
            last_q <= 1'b0; armed <= 1'b0; word <= '0;
            busy <= 1'b0; done <= 1'b0; err <= 1'b0; own <= 1'b0;
            scan_start <= 1'b0; scan_frame <= '0;
        end else begin
            scan_start <= 1'b0;
            if (st != S_IDLE && cmd_valid) err <= 1'b1;
            case (st)
                S_IDLE: if (cmd_valid) begin
                    if (cmd_reconf) begin
                        if (armed) begin
                            busy <= 1'b1; done <= 1'b0; err <= 1'b0;
                            scan_start <= 1'b1; scan_frame <= ir_frame(OP_CONFIG);
                            st <= S_CFG;
                        end else err <= 1'b1;
                    end else if (cmd_len == '0 || int'(cmd_chain) >= NCH) begin
                        err <= 1'b1;
                    end else begin
                        base <= cmd_base; len <= cmd_len; chain <= cmd_chain;
                        last_q <= cmd_last; armed <= 1'b0;
                        own <= 1'b1; busy <= 1'b1; done <= 1'b0; err <= 1'b0;
                        scan_start <= 1'b1; scan_frame <= ir_frame(OP_ERASE);
                        st <= S_ERASE;
                    end
                end
                S_ERASE: if (scan_done) begin
                    scan_start <= 1'b1; scan_frame <= ir_frame(OP_PROG);
                    st <= S_PIR;
                end
                S_PIR: if (scan_done) begin
                    idx <= '0; st <= S_FETCH;
                end
                S_FETCH: st <= S_FWAIT;
                S_FWAIT: begin
                    scan_start <= 1'b1; scan_frame <= dr_frame(seq_rdata);
                    st <= S_PDR;
                end
                S_PDR: if (scan_done) begin
                    if (at_end) begin
                        idx <= '0;
                        scan_start <= 1'b1; scan_frame <= ir_frame(OP_READ);
                        st <= S_RIR;
                    end else begin
                        idx <= idx + 1'b1; st <= S_FETCH;
                    end
                end
                S_RIR: if (scan_done) begin
                    scan_start <= 1'b1; scan_frame <= dr_frame('0);
                    st <= S_RDR;
                end
                S_RDR: if (scan_done) begin
                    word <= scan_tdo[3 +: DW]; st <= S_WBK;
                end
                S_WBK: begin
                    if (at_end) begin
                        own <= 1'b0; busy <= 1'b0; done <= 1'b1;
                        armed <= last_q; st <= S_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        scan_start <= 1'b1; scan_frame <= dr_frame('0);
                        st <= S_RDR;
                    end
                end
                S_CFG: if (scan_done) begin
                    busy <= 1'b0; done <= 1'b1; armed <= 1'b0; st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2: the SRAM is only held while a run is active.
    a_r2_own_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        own |-> busy);
    // R9: a command landing on a busy block always flags an error.
    a_r9_busy_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> err);
    // R8: at most one chain is driven.
    a_r8_chain_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chain_en));
    // R5: done and busy are never high together.
    a_r5_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R4: read-back writes happen only while the SRAM is owned.
    a_r4_write_owned: assert property (@(posedge clk) disable iff (!rst_n)
        seq_we |-> own);
endmodule

// File: rtl/prom_cfg_seq.sv
// Top: ties the command sequencer, SRAM ownership mux and JTAG master,
// and picks TDO from the enabled chain. TCK/TMS/TDI are shared by all chains.
module prom_cfg_seq
    import prom_cfg_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int AW   = 8,
    parameter int LW   = 8,
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] clk_div,
    input  logic            cmd_valid,
    input  logic            cmd_reconf,
    input  logic [CHW-1:0]  cmd_chain,
    input  logic [AW-1:0]   cmd_base,
    input  logic [LW-1:0]   cmd_len,
    input  logic            cmd_last,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic            host_gnt,
    input  logic [AW-1:0]   host_addr,
    input  logic            host_we,
    input  logic [DW-1:0]   host_wdata,
    output logic [DW-1:0]   host_rdata,
    output logic [AW-1:0]   sram_addr,
    output logic            sram_we,
    output logic [DW-1:0]   sram_wdata,
    input  logic [DW-1:0]   sram_rdata,
    output logic            jtag_tck,
    output logic            jtag_tms,
    output logic            jtag_tdi,
    input  logic [NCH-1:0]  jtag_tdo,
    output logic [NCH-1:0]  chain_en
);
    logic          own, seq_we, scan_start, scan_done, scan_busy, tdo_sel;
    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_wdata;
    frame_t        scan_frame;
    logic [FR-1:0] scan_tdo;

    assign host_gnt = !own;
    assign tdo_sel  = |(jtag_tdo & chain_en);

    prom_cfg_ctrl #(.NCH(NCH), .CHW(CHW), .AW(AW), .LW(LW)) u_ctrl (
        .clk, .rst_n, .cmd_valid, .cmd_reconf, .cmd_chain, .cmd_base,
        .cmd_len, .cmd_last, .busy, .done, .err, .own, .chain_en,
        .seq_addr, .seq_we, .seq_wdata, .seq_rdata(sram_rdata),
        .scan_start, .scan_frame, .scan_done, .scan_tdo
    );

    prom_sram_arb #(.AW(AW), .DW(DW)) u_arb (
        .own, .host_addr, .host_we, .host_wdata, .host_rdata,
        .seq_addr, .seq_we, .seq_wdata,
        .sram_addr, .sram_we, .sram_wdata, .sram_rdata
    );

    prom_jtag_scan #(.DIVW(DIVW)) u_jtag (
        .clk, .rst_n, .clk_div, .start(scan_start), .frame(scan_frame),
        .busy(scan_busy), .done(scan_done), .tdo_vec(scan_tdo),
        .tck(jtag_tck), .tms(jtag_tms), .tdi(jtag_tdi), .tdo_i(tdo_sel)
    );

    // R1: the JTAG clock stays low whenever the block is idle.
    a_r1_tck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !jtag_tck);
endmodule

// File: tb/prom_cfg_seq_tb.sv
module prom_cfg_seq_tb;
    localparam int NCH = 3, CHW = 2, AW = 8, LW = 8, DIVW = 8, DW = 16;
    localparam logic [7:0] C_ERASE = 8'h0D, C_PROG = 8'h06, C_READ = 8'h05, C_CFG = 8'h0E;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [DIVW-1:0] clk_div = 8'd1;
    logic cmd_valid = 0, cmd_reconf = 0, cmd_last = 0;
    logic [CHW-1:0] cmd_chain = '0;
    logic [AW-1:0] cmd_base = '0, host_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic host_we = 0;
    logic [DW-1:0] host_wdata = '0, host_rdata, sram_wdata, sram_rdata;
    logic busy, done, err, host_gnt, sram_we, jtag_tck, jtag_tms, jtag_tdi;
    logic [AW-1:0] sram_addr;
    logic [NCH-1:0] jtag_tdo, chain_en;

    prom_cfg_seq #(.NCH(NCH), .CHW(CHW), .AW(AW), .LW(LW), .DIVW(DIVW)) u_dut (
        .clk, .rst_n, .clk_div, .cmd_valid, .cmd_reconf, .cmd_chain, .cmd_base,
        .cmd_len, .cmd_last, .busy, .done, .err, .host_gnt, .host_addr, .host_we,
        .host_wdata, .host_rdata, .sram_addr, .sram_we, .sram_wdata, .sram_rdata,
        .jtag_tck, .jtag_tms, .jtag_tdi, .jtag_tdo, .chain_en);

    // SRAM model, registered read.
    logic [DW-1:0] sram [256];
    always @(posedge clk) begin
        if (sram_we) sram[sram_addr] <= sram_wdata;
        sram_rdata <= sram[sram_addr];
    end

    // TAP + PROM model.
    localparam int T_TLR=0, T_IDLE=1, T_SDR=2, T_CDR=3, T_SHD=4, T_E1D=5, T_PD=6, T_E2D=7,
                   T_UDR=8, T_SIR=9, T_CIR=10, T_SHI=11, T_E1I=12, T_PI=13, T_E2I=14, T_UIR=15;
    int ts = T_IDLE;
    logic [7:0] m_ir = '0, m_irs = '0;
    logic [DW-1:0] m_dr = '0;
    logic [DW-1:0] prom [16];
    int wptr = 0, rptr = 0, ir_n = 0, cfg_n = 0;
    logic [7:0] ir_log [64];
    int exp_chain = 0;

    always_comb begin
        jtag_tdo = '0;
        jtag_tdo[exp_chain] = m_dr[0];
    end

    always @(posedge jtag_tck) begin
        case (ts)
            T_CDR: if (m_ir == C_READ) begin m_dr = prom[rptr % 16]; rptr++; end
            T_SHD: m_dr = {jtag_tdi, m_dr[DW-1:1]};
            T_UDR: if (m_ir == C_PROG) begin prom[wptr % 16] = m_dr; wptr++; end
            T_SHI: m_irs = {jtag_tdi, m_irs[7:1]};
            T_UIR: begin
                m_ir = m_irs; ir_log[ir_n % 64] = m_irs; ir_n++;
                if (m_irs == C_ERASE) begin
                    for (int i = 0; i < 16; i++) prom[i] = '1;
                    wptr = 0;
                end
                if (m_irs == C_PROG) wptr = 0;
                if (m_irs == C_READ) rptr = 0;
                if (m_irs == C_CFG) cfg_n++;
            end
            default: ;
        endcase
        case (ts)
            T_TLR:  ts = jtag_tms ? T_TLR : T_IDLE;
            T_IDLE: ts = jtag_tms ? T_SDR : T_IDLE;
            T_SDR:  ts = jtag_tms ? T_SIR : T_CDR;
            T_CDR:  ts = jtag_tms ? T_E1D : T_SHD;
            T_SHD:  ts = jtag_tms ? T_E1D : T_SHD;
            T_E1D:  ts = jtag_tms ? T_UDR : T_PD;
            T_PD:   ts = jtag_tms ? T_E2D : T_PD;
            T_E2D:  ts = jtag_tms ? T_UDR : T_SHD;
            T_UDR:  ts = jtag_tms ? T_SDR : T_IDLE;
            T_SIR:  ts = jtag_tms ? T_TLR : T_CIR;
            T_CIR:  ts = jtag_tms ? T_E1I : T_SHI;
            T_SHI:  ts = jtag_tms ? T_E1I : T_SHI;
            T_E1I:  ts = jtag_tms ? T_UIR : T_PI;
            T_PI:   ts = jtag_tms ? T_E2I : T_PI;
            T_E2I:  ts = jtag_tms ? T_UIR : T_SHI;
            default: ts = jtag_tms ? T_SDR : T_IDLE;
        endcase
    end

    int checks = 0, failures = 0;
    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [7:0] b, input int i);
        return {b ^ 8'hA5, 8'(i * 17 + 3)};
    endfunction

    task automatic host_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_we = 1;
        @(negedge clk); host_we = 0;
    endtask
    task automatic host_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); host_addr = a;
        @(negedge clk); d = host_rdata;
    endtask
    task automatic send_cmd(input logic rc, input logic [CHW-1:0] ch, input logic [AW-1:0] b,
                            input logic [LW-1:0] l, input logic last);
        @(negedge clk);
        cmd_valid = 1; cmd_reconf = rc; cmd_chain = ch; cmd_base = b; cmd_len = l; cmd_last = last;
        @(negedge clk); cmd_valid = 0;
    endtask
    task automatic wait_idle;
        for (int n = 0; n < 40000 && busy; n++) @(negedge clk);
    endtask
    task automatic fill(input logic [AW-1:0] b, input int l);
        for (int i = 0; i < l; i++) host_wr(b + AW'(i), pat(b, i));
    endtask
    task automatic check_image(input logic [AW-1:0] b, input int l, input string req);
        logic [DW-1:0] d;
        check(wptr == l, req, wptr, l);
        for (int i = 0; i < l; i++) check(prom[i] == pat(b, i), req, prom[i], pat(b, i));
        for (int i = 0; i < l; i++) begin
            host_rd(b + AW'(l + i), d);
            check(d == pat(b, i), "R4 readback", d, pat(b, i));
        end
    endtask

    // {chain[1:0], base[7:0], len[7:0], last}
    localparam logic [18:0] VEC [3] = '{
        {2'd0, 8'h10, 8'd3, 1'b0},
        {2'd1, 8'h40, 8'd1, 1'b0},
        {2'd2, 8'h80, 8'd5, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        int ir0, c0, n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err, "R1 status", {busy, done, err}, 0);
        check(host_gnt && chain_en == 0 && !jtag_tck, "R1 idle pins", {host_gnt, chain_en, jtag_tck}, 5'b10000);
        repeat (50) @(negedge clk);
        check(ir_n == 0, "R1 no jtag", ir_n, 0);
        host_wr(8'hF0, 16'h1234);

        for (int v = 0; v < 3; v++) begin
            logic [1:0] ch; logic [7:0] b; logic [7:0] l; logic last;
            {ch, b, l, last} = VEC[v];
            fill(b, l);
            exp_chain = ch; ir0 = ir_n;
            send_cmd(0, ch, b, l, last);
            check(busy && !host_gnt, "R2 owned", {busy, host_gnt}, 2'b10);
            check(chain_en == (3'b1 << ch), "R8 chain_en", chain_en, 3'b1 << ch);
            host_wr(8'hF0, 16'hDEAD);
            host_rd(8'hF0, d);
            check(d == 0, "R2 rdata blocked", d, 0);
            wait_idle();
            @(negedge clk);
            check(done && !busy && host_gnt && !err, "R5 release", {done, busy, host_gnt, err}, 4'b1010);
            check(ir_n == ir0 + 3, "R3 ir count", ir_n - ir0, 3);
            check(ir_log[ir0] == C_ERASE && ir_log[ir0+1] == C_PROG, "R3 ir order",
                  {ir_log[ir0], ir_log[ir0+1]}, {C_ERASE, C_PROG});
            check(ir_log[ir0+2] == C_READ, "R4 ir read", ir_log[ir0+2], C_READ);
            check_image(b, l, "R3 prom image");
            host_rd(8'hF0, d);
            check(d == 16'h1234, "R2 host write dropped", d, 16'h1234);
        end

        // R6 reconfigure after final segment
        c0 = cfg_n;
        send_cmd(1, 0, 0, 0, 0);
        check(busy && !err, "R6 reconf accepted", {busy, err}, 2'b10);
        wait_idle(); @(negedge clk);
        check(cfg_n == c0 + 1 && done, "R6 config issued", cfg_n - c0, 1);
        check(ir_log[ir_n-1] == C_CFG, "R6 config code", ir_log[ir_n-1], C_CFG);
        n = ir_n;
        send_cmd(1, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        check(err && !busy && ir_n == n, "R6 second reconf rejected", {err, busy}, 2'b10);

        // R10 divider and R7 non-final segment
        clk_div = 8'd2;
        fill(8'h20, 2); exp_chain = 1;
        send_cmd(0, 1, 8'h20, 2, 0);
        @(posedge jtag_tck); #1;
        n = 0;
        while (jtag_tck) begin @(posedge clk); #1; n++; end
        check(n == 3, "R10 high half", n, 3);
        n = 0;
        while (!jtag_tck) begin @(posedge clk); #1; n++; end
        check(n == 3, "R10 low half", n, 3);
        wait_idle(); clk_div = 8'd1;
        @(negedge clk);
        check_image(8'h20, 2, "R10 image at div 2");
        c0 = cfg_n;
        send_cmd(1, 0, 0, 0, 0);
        repeat (20) @(negedge clk);
        check(err && !busy && cfg_n == c0, "R7 reconf after non-final", {err, busy}, 2'b10);

        // R8 bad chain, R11 zero length
        n = ir_n;
        send_cmd(0, 3, 8'h00, 2, 0);
        @(negedge clk);
        check(err && !busy && host_gnt, "R8 chain reject", {err, busy, host_gnt}, 3'b101);
        send_cmd(0, 0, 8'h00, 0, 0);
        repeat (20) @(negedge clk);
        check(err && !busy && ir_n == n, "R11 zero length reject", ir_n - n, 0);

        // R9 command while busy
        fill(8'h60, 2); exp_chain = 0; ir0 = ir_n;
        send_cmd(0, 0, 8'h60, 2, 1);
        check(!err, "R9 err cleared by accept", err, 0);
        repeat (100) @(negedge clk);
        send_cmd(0, 2, 8'h10, 3, 0);
        check(err && busy, "R9 busy reject", {err, busy}, 2'b11);
        wait_idle(); @(negedge clk);
        check(ir_n == ir0 + 3, "R9 run unaffected", ir_n - ir0, 3);
        check_image(8'h60, 2, "R9 image");
        c0 = cfg_n;
        send_cmd(1, 0, 0, 0, 0);
        wait_idle(); @(negedge clk);
        check(!err && cfg_n == c0 + 1, "R9 reconf after final", cfg_n - c0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule